// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a simple single-request interface inside a clocked design to an external asynchronous static RAM of 32768 bytes. A requester presents a read or a write with a 15-bit address and, for writes, one data byte. The controller then sequences the memory's three active-low strobes (chip select, output enable, write strobe), the address bus and a data bus that is split into outgoing data, incoming data and an output-enable for the pad drivers. A read returns its byte together with a one-cycle completion pulse. A write ends with the same pulse.

Every analogue timing interval is a parameter counted in system clock cycles. Each count is the nanosecond figure divided by the clock period and rounded up. Writes are timed by the write strobe while output enable stays low for the whole access. After the write strobe falls, the controller waits until the memory has let go of the data bus, then drives its byte for long enough to meet the setup, pulse-width and cycle minimums. It releases the bus on the same edge that ends the write. Reads hold the strobes for the access count and capture the bus on the edge where that count runs out.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, chip select, output enable and write strobe are high, the data drivers are off, the done pulse is low, ready is high, and the read-data and address outputs are zero.
- R2: A request is taken only on a clock edge where ready is high and valid is high. A valid request presented while an access is running changes no output and no memory content.
- R3: A read holds chip select and output enable low and the write strobe high for exactly RD_ACCESS_CYC cycles, starting the cycle after acceptance.
- R4: The read byte is captured on the edge at which the access count completes. It appears on the read-data output together with a done pulse lasting one cycle, and it is held until the next read completes.
- R5: A write holds chip select, output enable and the write strobe low. The data drivers stay off for the first WR_RELEASE_CYC cycles of the write strobe being low.
- R6: After that release wait, the drivers are on for exactly max(WR_SETUP_CYC, WR_PULSE_CYC−WR_RELEASE_CYC, WR_ADDR_END_CYC−WR_RELEASE_CYC, WR_CYCLE_CYC−WR_RELEASE_CYC) cycles, with at least one cycle, carrying the request's byte.
- R7: The write strobe, chip select and output enable rise on the same edge that turns the drivers off, and the done pulse follows for one cycle.
- R8: The memory address equals the accepted request's address and does not change while chip select is low.
- R9: The write strobe is low only while chip select is low, and the drivers are on only while the write strobe is low.
- R10: A request held valid through the done cycle is accepted on that cycle's edge, so accesses can follow back to back with chip select high for one cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken at the next edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_addr | output | 15 | Memory address bus |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_in | input | 8 | Data from the memory |
| sram_dq_oe | output | 1 | Pad driver enable for sram_dq_out |

## Verification
The assertions assume that reset is held for at least one clock edge before any check starts, so that every comparison with a previous cycle has a defined history. They also assume that the cycle parameters already include the rounding up from nanoseconds. The stimulus holds reset for several cycles and derives all counts in the bench from the nanosecond figures. It changes request inputs only away from the sampling edge. A bench memory model drives the incoming data bus only while chip select and output enable are low and the write strobe is high, which matches what the controller expects from the memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_WR_RELEASE,
    ST_WR_DRIVE
  } ctrl_state_t;

  function automatic int floor_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int ACCESS_CYC   = 6,
  parameter int RELEASE_CYC  = 2,
  parameter int DRIVE_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             done,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);

  ctrl_state_t state;

  assign ready   = (state == ST_IDLE);
  assign accept  = ready && req_valid;
  assign capture = (state == ST_RD_ACCESS) && tmr_expired;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? CNT_W'(RELEASE_CYC - 1) : CNT_W'(ACCESS_CYC - 1);
    end else if ((state == ST_WR_RELEASE) && tmr_expired) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(DRIVE_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            ce_n <= 1'b0;
            oe_n <= 1'b0;
            if (req_write) begin
              we_n  <= 1'b0;
              state <= ST_WR_RELEASE;
            end else begin
              state <= ST_RD_ACCESS;
            end
          end
        end
        ST_RD_ACCESS: begin
          if (tmr_expired) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_WR_RELEASE: begin
          if (tmr_expired) begin
            dq_oe <= 1'b1;
            state <= ST_WR_DRIVE;
          end
        end
        ST_WR_DRIVE: begin
          if (tmr_expired) begin
            dq_oe <= 1'b0;
            we_n  <= 1'b1;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Run-length counters used only by the window checks below.
  localparam logic [CNT_W:0] REL_V = (CNT_W+1)'(RELEASE_CYC);
  localparam logic [CNT_W:0] DRV_V = (CNT_W+1)'(DRIVE_CYC);
  logic [CNT_W:0] we_low_run;
  logic [CNT_W:0] drive_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_run <= '0;
      drive_run  <= '0;
    end else begin
      if (!we_n && !dq_oe && we_low_run != '1) we_low_run <= we_low_run + 1'b1;
      else if (we_n) we_low_run <= '0;
      if (dq_oe) drive_run <= drive_run + 1'b1;
      else drive_run <= '0;
    end
  end

  a_r9_we_needs_ce: assert property (@(posedge clk) disable iff (rst) !we_n |-> !ce_n);
  a_r9_drive_needs_we: assert property (@(posedge clk) disable iff (rst) dq_oe |-> !we_n);
  a_r5_oe_low_in_write: assert property (@(posedge clk) disable iff (rst) !we_n |-> !oe_n);
  a_r5_release_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (we_low_run >= REL_V));
  a_r6_drive_length: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_oe) |-> (drive_run == DRV_V));
  a_r7_off_with_we: assert property (@(posedge clk) disable iff (rst) $fell(dq_oe) |-> $rose(we_n));
  a_r7_we_with_off: assert property (@(posedge clk) disable iff (rst) $rose(we_n) |-> $fell(dq_oe));
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r3_read_strobes: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && we_n) |-> !oe_n);

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              ce_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        if (req_write) dq_out <= req_wdata;
      end
      if (capture) rdata <= dq_in;
    end
  end

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $past(!ce_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 15,
  parameter int DATA_W          = 8,
  parameter int RD_ACCESS_CYC   = 6,
  parameter int WR_RELEASE_CYC  = 2,
  parameter int WR_SETUP_CYC    = 3,
  parameter int WR_PULSE_CYC    = 4,
  parameter int WR_ADDR_END_CYC = 5,
  parameter int WR_CYCLE_CYC    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int ACC_C = floor_one(RD_ACCESS_CYC);
  localparam int REL_C = floor_one(WR_RELEASE_CYC);
  localparam int DRV_C = floor_one(max4(WR_SETUP_CYC, WR_PULSE_CYC - REL_C,
                                        WR_ADDR_END_CYC - REL_C, WR_CYCLE_CYC - REL_C));
  localparam int MAX_C = max4(ACC_C, REL_C, DRV_C, 1);
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept;
  logic             capture;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_ctrl_seq #(
    .CNT_W       (CNT_W),
    .ACCESS_CYC  (ACC_C),
    .RELEASE_CYC (REL_C),
    .DRIVE_CYC   (DRV_C)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (accept),
    .capture     (capture),
    .ready       (req_ready),
    .done        (rsp_done),
    .ce_n        (sram_ce_n),
    .oe_n        (sram_oe_n),
    .we_n        (sram_we_n),
    .dq_oe       (sram_dq_oe)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (sram_dq_in),
    .ce_n      (sram_ce_n),
    .mem_addr  (sram_addr),
    .dq_out    (sram_dq_out),
    .rdata     (rsp_rdata)
  );

  a_r4_rdata_held: assert property (@(posedge clk) disable iff (rst)
    !rsp_done |-> $stable(rsp_rdata));
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !sram_ce_n |-> !req_ready);

endmodule

// File: tb/test_sram_access_ctrl.sv
module test_sram_access_ctrl;

  localparam int CLK_PERIOD = 10;

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ACC = mx(cdiv(55), cdiv(25));
  localparam int REL = cdiv(20);
  localparam int WD  = mx(mx(cdiv(25), cdiv(40) - REL), mx(cdiv(45) - REL, cdiv(55) - REL));

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  rsp_rdata, sram_dq_out;
  logic [7:0]  sram_dq_in = 8'hEE;
  logic [14:0] sram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_access_ctrl #(
    .RD_ACCESS_CYC(ACC), .WR_RELEASE_CYC(REL), .WR_SETUP_CYC(cdiv(25)),
    .WR_PULSE_CYC(cdiv(40)), .WR_ADDR_END_CYC(cdiv(45)), .WR_CYCLE_CYC(cdiv(55))
  ) i_sram_access_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
  );

  int total = 0;
  int bad = 0;
  bit reported = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Memory model and reference contents.
  logic [7:0] sram_mem [int];
  logic [7:0] ref_mem [int];
  function automatic logic [7:0] bg(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  bit         pend_v = 0;
  int         pend_a = 0;
  logic [7:0] pend_d = '0;

  always @(posedge clk) begin
    if (pend_v && (sram_ce_n || sram_we_n)) begin
      sram_mem[pend_a] = pend_d;
      pend_v = 0;
    end
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
      pend_v = 1;
      pend_a = int'(sram_addr);
      pend_d = sram_dq_out;
    end
  end

  always @(negedge clk) begin
    if (!sram_ce_n && !sram_oe_n && sram_we_n)
      sram_dq_in = sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : bg(int'(sram_addr));
    else
      sram_dq_in = 8'hEE;
  end

  // Behavioural reference of the controller.
  int          m_cyc = 0;
  bit          m_wr = 0;
  bit          m_acc = 0;
  bit          m_done = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;
  logic [7:0]  m_rdata = '0;

  always @(posedge clk) begin
    m_acc  = 0;
    m_done = 0;
    if (rst) begin
      m_cyc = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
    end else if (m_cyc == 0) begin
      if (req_valid) begin
        m_cyc = 1; m_wr = req_write; m_addr = req_addr; m_acc = 1;
        if (req_write) m_wdata = req_wdata;
      end
    end else if (!m_wr) begin
      if (m_cyc == ACC) begin
        m_rdata = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : bg(int'(m_addr));
        m_done = 1; m_cyc = 0;
      end else m_cyc++;
    end else begin
      if (m_cyc == REL + WD) begin
        ref_mem[int'(m_addr)] = m_wdata;
        m_done = 1; m_cyc = 0;
      end else m_cyc++;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit busy;
      bit drv;
      busy = (m_cyc != 0);
      drv  = busy && m_wr && (m_cyc > REL);
      chk("R2", "req_ready", 32'(req_ready), 32'(!busy));
      chk("R3", "ce_n", 32'(sram_ce_n), 32'(!busy));
      chk("R3", "oe_n", 32'(sram_oe_n), 32'(!busy));
      chk("R5", "we_n", 32'(sram_we_n), 32'(!(busy && m_wr)));
      chk("R6", "dq_oe", 32'(sram_dq_oe), 32'(drv));
      chk("R7", "done", 32'(rsp_done), 32'(m_done));
      chk("R4", "rdata", 32'(rsp_rdata), 32'(m_rdata));
      chk("R8", "addr", 32'(sram_addr), 32'(m_addr));
      if (drv) chk("R6", "dq_out", 32'(sram_dq_out), 32'(m_wdata));
    end
  end

  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d, input bit keep);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do begin @(posedge clk); #1; end while (!m_acc);
    if (!keep) req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_cyc != 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog act=busy exp=finished");
    report();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "ce_n", 32'(sram_ce_n), 32'd1);
    chk("R1", "oe_n", 32'(sram_oe_n), 32'd1);
    chk("R1", "we_n", 32'(sram_we_n), 32'd1);
    chk("R1", "dq_oe", 32'(sram_dq_oe), 32'd0);
    chk("R1", "done", 32'(rsp_done), 32'd0);
    chk("R1", "ready", 32'(req_ready), 32'd1);
    chk("R1", "rdata", 32'(rsp_rdata), 32'd0);
    chk("R1", "addr", 32'(sram_addr), 32'd0);
    rst = 0;
    @(negedge clk);

    // R3 R4: reads of unwritten words at both address ends
    issue(0, 15'h0000, 8'h00, 0); wait_idle();
    issue(0, 15'h7FFF, 8'h00, 0); wait_idle();

    // R5 R6 R7: writes then read back
    issue(1, 15'h1234, 8'h3C, 0); wait_idle();
    issue(0, 15'h1234, 8'h00, 0); wait_idle();
    issue(1, 15'h0000, 8'hFF, 0); wait_idle();
    issue(1, 15'h7FFF, 8'h00, 0); wait_idle();
    issue(0, 15'h0000, 8'h00, 0); wait_idle();
    issue(0, 15'h7FFF, 8'h00, 0); wait_idle();

    // R10: back-to-back requests with valid held high
    issue(1, 15'h0042, 8'h5A, 1);
    issue(0, 15'h0042, 8'h00, 1);
    issue(1, 15'h0043, 8'hC3, 1);
    issue(0, 15'h0043, 8'h00, 0);
    wait_idle();

    // R2: valid requests while busy are ignored
    issue(1, 15'h0100, 8'h11, 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 15'h0200; req_wdata = 8'h99;
    repeat (3) @(negedge clk);
    req_valid = 0;
    wait_idle();
    issue(0, 15'h0200, 8'h00, 0); wait_idle();
    issue(0, 15'h0100, 8'h00, 0); wait_idle();

    // Mixed pattern (R3 R4 R5 R6 R8)
    for (int i = 0; i < 24; i++) begin
      logic [14:0] a;
      a = 15'((i * 1237 + 91) % 32768) & 15'h7F0F;
      issue(i % 3 != 2, a, 8'(i * 29 + 7), (i % 4) == 1);
      if ((i % 4) != 1) wait_idle();
    end
    req_valid = 0;
    wait_idle();
    report();
  end

endmodule